// File: doc/BRIEF.md
# Interrupt Mask and Acknowledge Controller

This block gathers four interrupt sources (a power key, two periodic timers and a serial link) onto one interrupt request line for a CPU. A single 8-bit control register, written and read by the CPU, holds one enable bit for each source. Each source has a pending latch. The latch is set by a rising edge of its event input while the source is enabled. It is cleared only when software writes a 0 to that source's enable bit, and that same write also masks the source. A request that is never acknowledged therefore keeps the line high, and the handler runs again every time the CPU re-enables interrupts.

The register also carries a power bit. With that bit at 0, a halt indication from the CPU moves a two-state power machine from `PWR_FULL` to `PWR_SLEEP`. In `PWR_SLEEP` the timers are stopped, timer events are ignored and the display is put in standby. An enabled key or link edge wakes the machine back to `PWR_FULL` and raises the request in the same cycle. The transitions are `enter_sleep` (halt with the power bit at 0) and `wake` (enabled key or link edge). The usual operating value is 0x0B: power key and first timer enabled, full power, second timer and link masked.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset all pending latches are clear, every source is masked, the power bit is 1, `irq` is 0, `low_pwr` and `disp_standby` are 0, `tmr_run` is 1 and `rd_data` reads 0x00.
- R2: The enable bits sit at register bit 0 (power key), bit 1 (first timer), bit 2 (second timer) and bit 4 (link). `rd_data` returns these four bits in place and reads 0 in bits 3, 5, 6 and 7.
- R3: A source's pending latch is set by a 0-to-1 transition of its event input while its enable bit is 1. A held high level sets nothing further, and an edge on a masked source is ignored.
- R4: A write with a 0 in a source's enable bit clears that source's pending latch and masks it. When an edge arrives in the same cycle as such a write, the write wins and the edge is dropped.
- R5: `irq` is high whenever any pending latch is set, and it stays high until every set latch has been cleared by a write.
- R6: With register bit 3 at 0, `cpu_halted` high moves the machine from `PWR_FULL` to `PWR_SLEEP`, and `low_pwr` is 1 after the next edge. With bit 3 at 1, a halt has no effect on power.
- R7: In `PWR_SLEEP`, `disp_standby` is 1, `tmr_run` is 0 and timer edges set no pending latch.
- R8: In `PWR_SLEEP`, an enabled power key or link edge returns the machine to `PWR_FULL` and raises `irq` at the same clock edge. An edge from a masked key or link source does not wake the machine.
- R9: A register write takes effect at the next clock edge. An edge that arrives in the same cycle as the write that enables its source is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value (enable bits) |
| key_evt | input | 1 | Power key event |
| tmr0_evt | input | 1 | First timer tick |
| tmr1_evt | input | 1 | Second timer tick |
| link_evt | input | 1 | Serial link activity |
| cpu_halted | input | 1 | CPU is executing a halt |
| irq | output | 1 | Interrupt request to the CPU |
| low_pwr | output | 1 | System is in the low-power state |
| disp_standby | output | 1 | Display standby request |
| tmr_run | output | 1 | Timer hardware allowed to run |

## Verification
The assertions assume that a pending latch can only go low through a register write. They also assume that event inputs are synchronous levels, sampled once per cycle, so that an edge is one low-to-high step between two cycles. The stimulus holds every event input low through reset and changes it only at the falling clock edge. It asserts `cpu_halted` only while no write is issued, which matches a CPU that cannot write while it is halted.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
    localparam int REG_W   = 8;
    localparam int SRC_CNT = 4;
    localparam int PWR_BIT = 3;

    // source index: 0 power key, 1 first timer, 2 second timer, 3 link
    localparam logic [SRC_CNT-1:0] TIMER_SRC = 4'b0110;
    localparam logic [SRC_CNT-1:0] WAKE_SRC  = 4'b1001;

    typedef enum logic [0:0] {
        PWR_FULL  = 1'b0,
        PWR_SLEEP = 1'b1
    } pwr_state_e;

    // register bit for a source: the power bit sits between timer 2 and link
    function automatic int src_bit(input int idx);
        return (idx < PWR_BIT) ? idx : idx + 1;
    endfunction
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic en_i,
    input  logic allow_i,
    input  logic clr_i,
    output logic rise_o,
    output logic pend_o
);
    logic evt_q;
    logic pend_q;

    assign rise_o = evt_i & ~evt_q;
    assign pend_o = pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            evt_q <= evt_i;
            if (clr_i)
                pend_q <= 1'b0;
            else if (rise_o && en_i && allow_i)
                pend_q <= 1'b1;
        end
    end

    // R3 R7
    masked_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(en_i && allow_i && !clr_i));

    // R4
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !pend_q);
endmodule

// File: rtl/irq_pwr_fsm.sv
module irq_pwr_fsm
    import irq_mask_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_i,
    input  logic keep_pwr_i,
    input  logic wake_i,
    output logic sleep_o,
    output logic standby_o,
    output logic tmr_run_o
);
    pwr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_FULL:  if (halt_i && !keep_pwr_i) state_d = PWR_SLEEP;
            PWR_SLEEP: if (wake_i)                state_d = PWR_FULL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_FULL;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PWR_FULL: begin
                sleep_o   = 1'b0;
                standby_o = 1'b0;
                tmr_run_o = 1'b1;
            end
            PWR_SLEEP: begin
                sleep_o   = 1'b1;
                standby_o = 1'b1;
                tmr_run_o = 1'b0;
            end
        endcase
    end

    // R6
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_o && halt_i && !keep_pwr_i) |=> sleep_o);

    // R6
    keep_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_o && keep_pwr_i) |=> !sleep_o);

    // R8
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && wake_i) |=> !sleep_o);
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irq_mask_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             key_evt,
    input  logic             tmr0_evt,
    input  logic             tmr1_evt,
    input  logic             link_evt,
    input  logic             cpu_halted,
    output logic             irq,
    output logic             low_pwr,
    output logic             disp_standby,
    output logic             tmr_run
);
    logic [SRC_CNT-1:0] en_q;
    logic               keep_pwr_q;
    logic [SRC_CNT-1:0] evt;
    logic [SRC_CNT-1:0] rise;
    logic [SRC_CNT-1:0] pend;
    logic [SRC_CNT-1:0] clr;
    logic [REG_W-1:0]   src_mask;
    logic               sleeping;
    logic               wake;

    assign evt = {link_evt, tmr1_evt, tmr0_evt, key_evt};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= '0;
            keep_pwr_q <= 1'b1;
        end else if (wr_en) begin
            for (int i = 0; i < SRC_CNT; i++) en_q[i] <= wr_data[src_bit(i)];
            keep_pwr_q <= wr_data[PWR_BIT];
        end
    end

    always_comb begin
        rd_data  = '0;
        src_mask = '0;
        for (int i = 0; i < SRC_CNT; i++) begin
            rd_data[src_bit(i)]  = en_q[i];
            src_mask[src_bit(i)] = 1'b1;
        end
    end

    for (genvar g = 0; g < SRC_CNT; g++) begin : g_src
        localparam int BP = src_bit(g);
        assign clr[g] = wr_en & ~wr_data[BP];

        irq_src_latch u_latch (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt[g]),
            .en_i    (en_q[g]),
            .allow_i (~(TIMER_SRC[g] & sleeping)),
            .clr_i   (clr[g]),
            .rise_o  (rise[g]),
            .pend_o  (pend[g])
        );
    end

    assign wake = |(rise & en_q & WAKE_SRC & ~clr);
    assign irq  = |pend;

    irq_pwr_fsm u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_i     (cpu_halted),
        .keep_pwr_i (keep_pwr_q),
        .wake_i     (wake),
        .sleep_o    (sleeping),
        .standby_o  (disp_standby),
        .tmr_run_o  (tmr_run)
    );

    assign low_pwr = sleeping;

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en) |=> irq);

    // R4
    ack_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wr_data & src_mask) == '0)) |=> !irq);

    // R8
    wake_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(low_pwr) |-> irq);
endmodule

// File: tb/irq_mask_ctrl_tb.sv
module irq_mask_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       key_evt = 1'b0, tmr0_evt = 1'b0, tmr1_evt = 1'b0, link_evt = 1'b0;
    logic       cpu_halted = 1'b0;
    logic       irq, low_pwr, disp_standby, tmr_run;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    irq_mask_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .key_evt(key_evt), .tmr0_evt(tmr0_evt), .tmr1_evt(tmr1_evt), .link_evt(link_evt),
        .cpu_halted(cpu_halted), .irq(irq), .low_pwr(low_pwr),
        .disp_standby(disp_standby), .tmr_run(tmr_run)
    );

    // {wr, data[8], evt{link,tmr1,tmr0,key}[4], halt, exp_irq, exp_lp, exp_rd[8]}
    localparam int NV = 26;
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 8'h0B, 4'h0, 1'b0, 1'b0, 1'b0, 8'h03}, // 0  R2 normal value
        {1'b0, 8'h00, 4'h2, 1'b0, 1'b1, 1'b0, 8'h03}, // 1  R3 timer0 edge
        {1'b0, 8'h00, 4'h2, 1'b0, 1'b1, 1'b0, 8'h03}, // 2  R5 held
        {1'b1, 8'h09, 4'h0, 1'b0, 1'b0, 1'b0, 8'h01}, // 3  R4 ack timer0
        {1'b1, 8'h0B, 4'h0, 1'b0, 1'b0, 1'b0, 8'h03}, // 4
        {1'b0, 8'h00, 4'h4, 1'b0, 1'b0, 1'b0, 8'h03}, // 5  R3 masked timer1
        {1'b0, 8'h00, 4'h8, 1'b0, 1'b0, 1'b0, 8'h03}, // 6  R3 masked link
        {1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 1'b0, 8'h03}, // 7
        {1'b1, 8'h09, 4'h2, 1'b0, 1'b0, 1'b0, 8'h01}, // 8  R4 clear beats edge
        {1'b1, 8'h0B, 4'h0, 1'b0, 1'b0, 1'b0, 8'h03}, // 9
        {1'b0, 8'h00, 4'h1, 1'b0, 1'b1, 1'b0, 8'h03}, // 10 R3 key edge
        {1'b0, 8'h00, 4'h0, 1'b0, 1'b1, 1'b0, 8'h03}, // 11 R5 held
        {1'b1, 8'h0A, 4'h0, 1'b0, 1'b0, 1'b0, 8'h02}, // 12 R4 ack key
        {1'b1, 8'h13, 4'h0, 1'b0, 1'b0, 1'b0, 8'h13}, // 13 R2 arm sleep
        {1'b0, 8'h00, 4'h0, 1'b1, 1'b0, 1'b1, 8'h13}, // 14 R6 enter sleep
        {1'b0, 8'h00, 4'h2, 1'b1, 1'b0, 1'b1, 8'h13}, // 15 R7 timer blocked
        {1'b0, 8'h00, 4'h0, 1'b1, 1'b0, 1'b1, 8'h13}, // 16
        {1'b0, 8'h00, 4'h8, 1'b1, 1'b1, 1'b0, 8'h13}, // 17 R8 link wake
        {1'b0, 8'h00, 4'h0, 1'b0, 1'b1, 1'b0, 8'h13}, // 18
        {1'b1, 8'h0B, 4'h0, 1'b0, 1'b0, 1'b0, 8'h03}, // 19 R4 ack link
        {1'b0, 8'h00, 4'h0, 1'b1, 1'b0, 1'b0, 8'h03}, // 20 R6 kept powered
        {1'b0, 8'h00, 4'h3, 1'b0, 1'b1, 1'b0, 8'h03}, // 21 R3 two edges
        {1'b1, 8'h0A, 4'h0, 1'b0, 1'b1, 1'b0, 8'h02}, // 22 R5 one left
        {1'b1, 8'h08, 4'h0, 1'b0, 1'b0, 1'b0, 8'h00}, // 23 R5 all cleared
        {1'b1, 8'h0B, 4'h1, 1'b0, 1'b0, 1'b0, 8'h03}, // 24 R9 enable+edge dropped
        {1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 1'b0, 8'h03}  // 25 R9
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic step(input logic w, input logic [7:0] d, input logic [3:0] e, input logic h);
        @(negedge clk);
        wr_en = w; wr_data = d; cpu_halted = h;
        {link_evt, tmr1_evt, tmr0_evt, key_evt} = e;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 low_pwr", {7'd0, low_pwr}, 8'h00);
        check("R1 standby/tmr_run", {6'd0, disp_standby, tmr_run}, 8'h01);
        check("R1 rd_data", rd_data, 8'h00);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][23], VEC[i][22:15], VEC[i][14:11], VEC[i][10]);
            check($sformatf("R2-R9 table %0d irq", i), {7'd0, irq}, {7'd0, VEC[i][9]});
            check($sformatf("R6 R8 table %0d low_pwr", i), {7'd0, low_pwr}, {7'd0, VEC[i][8]});
            check($sformatf("R2 table %0d rd_data", i), rd_data, VEC[i][7:0]);
        end

        // R7 R8: link only, sleep armed
        step(1'b1, 8'h10, 4'h0, 1'b0);
        check("R2 rd link only", rd_data, 8'h10);
        step(1'b0, 8'h00, 4'h0, 1'b1);
        check("R7 standby/tmr_run in sleep", {6'd0, disp_standby, tmr_run}, 8'h02);
        step(1'b0, 8'h00, 4'h1, 1'b1);
        check("R8 masked key no wake", {6'd0, low_pwr, irq}, 8'h02);
        step(1'b0, 8'h00, 4'h8, 1'b1);
        check("R8 link wake", {6'd0, low_pwr, irq}, 8'h01);
        check("R7 standby/tmr_run after wake", {6'd0, disp_standby, tmr_run}, 8'h01);
        step(1'b0, 8'h00, 4'h0, 1'b0);

        // R1: reset while a request is pending
        @(negedge clk) rst_n = 1'b0;
        #2;
        check("R1 mid-run irq", {7'd0, irq}, 8'h00);
        check("R1 mid-run rd_data", rd_data, 8'h00);
        @(negedge clk) rst_n = 1'b1;
        step(1'b0, 8'h00, 4'h0, 1'b1);
        check("R1 power bit 1 after reset", {7'd0, low_pwr}, 8'h00);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule